// File: doc/BRIEF.md
# CAN message buffer state controller

This block keeps the 4-bit status code of each buffer in a small array of CAN message buffers. Each buffer follows a fixed state machine that covers one-shot data transmission, remote-frame requests, automatic answers to incoming remote frames, and reception of data frames with overflow tracking. A buffer moves between states on CPU writes of a state code, on per-buffer strobes from the protocol engine (arbitration grant, transmit completion, transmit failure, data frame received, remote frame received), and never on its own.

Selected transitions raise a per-buffer pending flag. A separate error pending bit records detected bus errors. The CPU enables each buffer's interrupt individually and clears pending flags by writing ones. The interrupt line is the OR of the enabled pending flags and the error bit. All outputs are registered.

Top module: `canbuf_state_ctrl`

## Requirements
- R1: While and after reset every buffer holds code 1000 (idle), all pending flags, the error bit, the interrupt enables and `irq_o` are 0, and every remote-request marker is cleared.
- R2: A CPU write to a buffer that is not busy loads the written code in the next cycle when the code is one of 1000 (idle), 1100 (send once), 1110 (queued remote answer), 1010 (remote armed) or 0010 (receive ready). Any other code (0100, 0110, 1101, 1111 or unused values) leaves the state unchanged. A write of 1100 also stores `wr_rmt` as the buffer's remote-request marker.
- R3: A grant moves 1100 to 1101 and 1110 to 1111. A grant in any other state has no effect. Without a grant, a buffer in 1100 or 1110 stays there for as long as needed.
- R4: A transmit failure returns 1101 to 1100 and 1111 to 1110 and sets no pending flag.
- R5: A transmit completion in 1101 moves to 0010 when the remote-request marker is set and to 1000 otherwise. Both cases set the buffer's pending flag.
- R6: A transmit completion in 1111 moves to 1010. A remote frame received in 1010 moves to 1110. Both set the pending flag.
- R7: A received data frame moves 0010 to 0100 (full), and 0100 or 0110 to 0110 (overrun), setting the pending flag each time. Received frames are ignored in all other states.
- R8: CPU writes to a buffer in 1101 or 1111 are ignored. With no completion or failure the state holds.
- R9: When an engine strobe changes a buffer's state, a CPU write to that buffer in the same cycle is ignored. Completion takes precedence over failure.
- R10: A pending flag clears when the CPU writes a 1 to its bit; a set in the same cycle wins. `err_det` sets the error bit, and a write with `clr_err` clears it, with the set winning.
- R11: `irq_o` equals the OR of (pending AND enable) over all buffers, ORed with the error bit. It changes in the same cycle as the flags and enables it depends on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU state-code write strobe |
| wr_idx | input | IDXW | Buffer addressed by the write |
| wr_code | input | 4 | State code written |
| wr_rmt | input | 1 | Remote-request marker stored with a 1100 write |
| ien_we | input | 1 | Interrupt enable register write strobe |
| ien_data | input | NBUF | New interrupt enable bits |
| clr_we | input | 1 | Pending clear strobe |
| clr_pend | input | NBUF | Write-one-to-clear mask for buffer pending flags |
| clr_err | input | 1 | Write-one-to-clear for the error bit |
| grant | input | NBUF | Per-buffer transmit scheduled strobe |
| tx_done | input | NBUF | Per-buffer transmit completed strobe |
| tx_fail | input | NBUF | Per-buffer transmit failed strobe |
| rx_data | input | NBUF | Per-buffer data frame received strobe |
| rx_remote | input | NBUF | Per-buffer matching remote frame received strobe |
| err_det | input | 1 | CAN error detected strobe |
| state_o | output | 4*NBUF | Packed state codes, buffer i at bits [4i+3:4i] |
| pend_o | output | NBUF | Per-buffer pending flags |
| err_o | output | 1 | Error pending bit |
| irq_o | output | 1 | Combined interrupt request |

## Verification
On every cycle the assertions check that state codes stay within the nine legal values, that grants advance requesting buffers, that a busy buffer holds under CPU writes when no engine strobe arrives, that each pending set and write-one clear reaches the flag register, and that a pending error keeps the interrupt asserted. The bench's scenarios are the only way to show the full transition table: the remote-request path through receive ready, the remote answer loop, overrun, precedence between simultaneous strobes and writes, and the exact value of the interrupt under changing enables. A cycle-accurate model in the bench compares every output each cycle.

// File: rtl/canbuf_pkg.sv
package canbuf_pkg;

  typedef enum logic [3:0] {
    ST_IDLE     = 4'b1000,
    ST_SEND     = 4'b1100,
    ST_SENDBUSY = 4'b1101,
    ST_RSPQ     = 4'b1110,
    ST_RSPBUSY  = 4'b1111,
    ST_RMTARM   = 4'b1010,
    ST_RXWAIT   = 4'b0010,
    ST_RXFULL   = 4'b0100,
    ST_RXOVR    = 4'b0110
  } buf_st_e;

  function automatic logic cpu_writable(input logic [3:0] code);
    return (code == ST_IDLE)   || (code == ST_SEND) || (code == ST_RSPQ) ||
           (code == ST_RMTARM) || (code == ST_RXWAIT);
  endfunction

endpackage

// File: rtl/canbuf_slot.sv
module canbuf_slot
  import canbuf_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_hit,
  input  logic [3:0] wr_code,
  input  logic       wr_rmt,
  input  logic       grant,
  input  logic       tx_done,
  input  logic       tx_fail,
  input  logic       rx_data,
  input  logic       rx_remote,
  output logic [3:0] state_o,
  output logic       evt_o
);

  buf_st_e st_q, st_n;
  logic    rmt_q, rmt_n;
  logic    cpu_ok;

  always_comb begin
    st_n   = st_q;
    rmt_n  = rmt_q;
    evt_o  = 1'b0;
    cpu_ok = 1'b0;
    case (st_q)
      ST_SEND: begin
        if (grant) st_n = ST_SENDBUSY;
        else       cpu_ok = 1'b1;
      end
      ST_RSPQ: begin
        if (grant) st_n = ST_RSPBUSY;
        else       cpu_ok = 1'b1;
      end
      ST_SENDBUSY: begin
        if (tx_done) begin
          st_n  = rmt_q ? ST_RXWAIT : ST_IDLE;
          evt_o = 1'b1;
        end else if (tx_fail) begin
          st_n = ST_SEND;
        end
      end
      ST_RSPBUSY: begin
        if (tx_done) begin
          st_n  = ST_RMTARM;
          evt_o = 1'b1;
        end else if (tx_fail) begin
          st_n = ST_RSPQ;
        end
      end
      ST_RMTARM: begin
        if (rx_remote) begin
          st_n  = ST_RSPQ;
          evt_o = 1'b1;
        end else cpu_ok = 1'b1;
      end
      ST_RXWAIT: begin
        if (rx_data) begin
          st_n  = ST_RXFULL;
          evt_o = 1'b1;
        end else cpu_ok = 1'b1;
      end
      ST_RXFULL, ST_RXOVR: begin
        if (rx_data) begin
          st_n  = ST_RXOVR;
          evt_o = 1'b1;
        end else cpu_ok = 1'b1;
      end
      default: cpu_ok = 1'b1;
    endcase
    if (cpu_ok && wr_hit && cpu_writable(wr_code)) begin
      st_n = buf_st_e'(wr_code);
      if (wr_code == ST_SEND) rmt_n = wr_rmt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      rmt_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      rmt_q <= rmt_n;
    end
  end

  assign state_o = st_q;

  // R2: only the nine defined codes ever appear
  a_r2_legal_code: assert property (@(posedge clk) disable iff (rst)
    st_q inside {ST_IDLE, ST_SEND, ST_SENDBUSY, ST_RSPQ, ST_RSPBUSY,
                 ST_RMTARM, ST_RXWAIT, ST_RXFULL, ST_RXOVR});

  // R3: a grant advances a one-shot request
  a_r3_grant_send: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SEND && grant) |=> st_q == ST_SENDBUSY);

  // R8: busy state holds against CPU writes
  a_r8_busy_hold: assert property (@(posedge clk) disable iff (rst)
    ((st_q == ST_SENDBUSY || st_q == ST_RSPBUSY) && !tx_done && !tx_fail) |=> $stable(st_q));

  // R5: completion of a one-shot send always reports
  a_r5_done_evt: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SENDBUSY && tx_done) |-> evt_o);

endmodule

// File: rtl/canbuf_irq.sv
module canbuf_irq #(
  parameter int NBUF = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NBUF-1:0] evt,
  input  logic            ien_we,
  input  logic [NBUF-1:0] ien_data,
  input  logic            clr_we,
  input  logic [NBUF-1:0] clr_pend,
  input  logic            clr_err,
  input  logic            err_det,
  output logic [NBUF-1:0] pend_o,
  output logic            err_o,
  output logic            irq_o
);

  logic [NBUF-1:0] pend_q, pend_n, ien_q, ien_n, clr_m;
  logic            err_q, err_n;

  always_comb begin
    clr_m  = clr_we ? clr_pend : '0;
    pend_n = (pend_q & ~clr_m) | evt;
    err_n  = (err_q & ~(clr_we & clr_err)) | err_det;
    ien_n  = ien_we ? ien_data : ien_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      err_q  <= 1'b0;
      ien_q  <= '0;
      irq_o  <= 1'b0;
    end else begin
      pend_q <= pend_n;
      err_q  <= err_n;
      ien_q  <= ien_n;
      irq_o  <= (|(pend_n & ien_n)) | err_n;
    end
  end

  assign pend_o = pend_q;
  assign err_o  = err_q;

  // R10: every reported transition lands in the flag register
  a_r10_set: assert property (@(posedge clk) disable iff (rst)
    (|evt) |=> ((pend_q & $past(evt)) == $past(evt)));

  // R10: write-one clears bits not set in the same cycle
  a_r10_clear: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> ((pend_q & $past(clr_pend & ~evt)) == '0));

  // R10: an error strobe is recorded
  a_r10_err: assert property (@(posedge clk) disable iff (rst)
    err_det |=> err_q);

  // R11: a pending error always requests an interrupt
  a_r11_err_irq: assert property (@(posedge clk) disable iff (rst)
    err_q |-> irq_o);

endmodule

// File: rtl/canbuf_state_ctrl.sv
module canbuf_state_ctrl #(
  parameter int NBUF = 4,
  localparam int IDXW = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDXW-1:0]   wr_idx,
  input  logic [3:0]        wr_code,
  input  logic              wr_rmt,
  input  logic              ien_we,
  input  logic [NBUF-1:0]   ien_data,
  input  logic              clr_we,
  input  logic [NBUF-1:0]   clr_pend,
  input  logic              clr_err,
  input  logic [NBUF-1:0]   grant,
  input  logic [NBUF-1:0]   tx_done,
  input  logic [NBUF-1:0]   tx_fail,
  input  logic [NBUF-1:0]   rx_data,
  input  logic [NBUF-1:0]   rx_remote,
  input  logic              err_det,
  output logic [4*NBUF-1:0] state_o,
  output logic [NBUF-1:0]   pend_o,
  output logic              err_o,
  output logic              irq_o
);

  logic [NBUF-1:0] evt;

  for (genvar i = 0; i < NBUF; i++) begin : g_slot
    canbuf_slot u_slot (
      .clk       (clk),
      .rst       (rst),
      .wr_hit    (wr_en && (wr_idx == IDXW'(i))),
      .wr_code   (wr_code),
      .wr_rmt    (wr_rmt),
      .grant     (grant[i]),
      .tx_done   (tx_done[i]),
      .tx_fail   (tx_fail[i]),
      .rx_data   (rx_data[i]),
      .rx_remote (rx_remote[i]),
      .state_o   (state_o[4*i +: 4]),
      .evt_o     (evt[i])
    );
  end

  canbuf_irq #(.NBUF(NBUF)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .evt      (evt),
    .ien_we   (ien_we),
    .ien_data (ien_data),
    .clr_we   (clr_we),
    .clr_pend (clr_pend),
    .clr_err  (clr_err),
    .err_det  (err_det),
    .pend_o   (pend_o),
    .err_o    (err_o),
    .irq_o    (irq_o)
  );

endmodule

// File: tb/tb_canbuf_state_ctrl.sv
module tb_canbuf_state_ctrl;
  localparam int NBUF = 4;
  localparam int IDXW = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 0, wr_rmt = 0, ien_we = 0, clr_we = 0, clr_err = 0, err_det = 0;
  logic [IDXW-1:0] wr_idx = '0;
  logic [3:0] wr_code = '0;
  logic [NBUF-1:0] ien_data = '0, clr_pend = '0, grant = '0, tx_done = '0,
                   tx_fail = '0, rx_data = '0, rx_remote = '0;
  logic [4*NBUF-1:0] state_o;
  logic [NBUF-1:0] pend_o;
  logic err_o, irq_o;

  always #2.5 clk = ~clk;

  canbuf_state_ctrl #(.NBUF(NBUF)) dut (.*);

  int total = 0, bad = 0;
  logic [3:0] m_st [NBUF];
  logic m_rf [NBUF];
  string m_tag [NBUF];
  logic [NBUF-1:0] m_pend, m_ien;
  logic m_err, m_irq;

  function automatic logic legal_wr(input logic [3:0] c);
    return c == 4'b1000 || c == 4'b1100 || c == 4'b1110 || c == 4'b1010 || c == 4'b0010;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic clear_in();
    wr_en = 0; ien_we = 0; clr_we = 0; clr_err = 0; err_det = 0;
    clr_pend = '0; grant = '0; tx_done = '0; tx_fail = '0; rx_data = '0; rx_remote = '0;
  endtask

  // compute model next state from current inputs, advance one clock, compare
  task automatic cycle();
    logic [3:0] ns [NBUF];
    logic nrf [NBUF];
    logic [NBUF-1:0] ev, ien_n;
    logic err_n;
    ev = '0;
    for (int i = 0; i < NBUF; i++) begin
      logic cpu;
      logic [3:0] s;
      s = m_st[i]; ns[i] = s; nrf[i] = m_rf[i]; cpu = 0; m_tag[i] = "R2";
      case (s)
        4'b1100: if (grant[i]) begin ns[i] = 4'b1101; m_tag[i] = "R3"; end else cpu = 1;
        4'b1110: if (grant[i]) begin ns[i] = 4'b1111; m_tag[i] = "R3"; end else cpu = 1;
        4'b1101: begin
          m_tag[i] = "R8";
          if (tx_done[i]) begin ns[i] = m_rf[i] ? 4'b0010 : 4'b1000; ev[i] = 1; m_tag[i] = "R5"; end
          else if (tx_fail[i]) begin ns[i] = 4'b1100; m_tag[i] = "R4"; end
        end
        4'b1111: begin
          m_tag[i] = "R8";
          if (tx_done[i]) begin ns[i] = 4'b1010; ev[i] = 1; m_tag[i] = "R6"; end
          else if (tx_fail[i]) begin ns[i] = 4'b1110; m_tag[i] = "R4"; end
        end
        4'b1010: if (rx_remote[i]) begin ns[i] = 4'b1110; ev[i] = 1; m_tag[i] = "R6"; end else cpu = 1;
        4'b0010: if (rx_data[i]) begin ns[i] = 4'b0100; ev[i] = 1; m_tag[i] = "R7"; end else cpu = 1;
        4'b0100, 4'b0110: if (rx_data[i]) begin ns[i] = 4'b0110; ev[i] = 1; m_tag[i] = "R7"; end else cpu = 1;
        default: cpu = 1;
      endcase
      if (!cpu && wr_en && wr_idx == IDXW'(i) && m_tag[i] != "R8") m_tag[i] = "R9";
      if (cpu && wr_en && wr_idx == IDXW'(i) && legal_wr(wr_code)) begin
        ns[i] = wr_code;
        if (wr_code == 4'b1100) nrf[i] = wr_rmt;
      end
    end
    ien_n = ien_we ? ien_data : m_ien;
    err_n = (m_err & ~(clr_we & clr_err)) | err_det;
    @(negedge clk);
    for (int i = 0; i < NBUF; i++) begin m_st[i] = ns[i]; m_rf[i] = nrf[i]; end
    m_pend = (m_pend & ~(clr_we ? clr_pend : '0)) | ev;
    m_err = err_n;
    m_ien = ien_n;
    m_irq = (|(m_pend & m_ien)) | m_err;
    clear_in();
    for (int i = 0; i < NBUF; i++) chk(m_tag[i], 32'(state_o[4*i +: 4]), 32'(m_st[i]));
    chk("R10", 32'(pend_o), 32'(m_pend));
    chk("R10", 32'(err_o), 32'(m_err));
    chk("R11", 32'(irq_o), 32'(m_irq));
  endtask

  task automatic wr(input int idx, input logic [3:0] code, input logic rmt);
    wr_en = 1; wr_idx = IDXW'(idx); wr_code = code; wr_rmt = rmt;
  endtask

  logic finished = 0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    for (int i = 0; i < NBUF; i++) begin m_st[i] = 4'b1000; m_rf[i] = 0; end
    m_pend = '0; m_ien = '0; m_err = 0; m_irq = 0;
    repeat (3) @(negedge clk);
    // R1: reset values
    for (int i = 0; i < NBUF; i++) chk("R1", 32'(state_o[4*i +: 4]), 32'h8);
    chk("R1", 32'(pend_o), 0); chk("R1", 32'(err_o), 0); chk("R1", 32'(irq_o), 0);
    rst = 0;
    cycle();

    // R2 / R3: request, delayed grant, grant
    wr(0, 4'b1100, 0); cycle();
    cycle(); cycle();                       // R3 held while another message wins
    grant[0] = 1; cycle();
    wr(0, 4'b1000, 0); cycle();             // R8 write ignored while busy
    tx_fail[0] = 1; cycle();                // R4 back to request
    grant[0] = 1; cycle();
    tx_done[0] = 1; cycle();                // R5 to idle with pending
    ien_we = 1; ien_data = 4'b0001; cycle(); // R11 enabled flag drives irq
    clr_we = 1; clr_pend = 4'b0001; cycle(); // R10 clear
    // R5 remote-request path, then R7 reception and overrun
    wr(1, 4'b1100, 1); cycle();
    grant[1] = 1; cycle();
    tx_done[1] = 1; cycle();
    rx_data[1] = 1; cycle();
    rx_data[1] = 1; cycle();
    rx_data[1] = 1; cycle();
    wr(1, 4'b0100, 0); cycle();             // R2 non-writable code ignored
    // R6 remote answer loop
    wr(2, 4'b1010, 0); cycle();
    rx_remote[2] = 1; cycle();
    grant[2] = 1; cycle();
    tx_fail[2] = 1; cycle();
    grant[2] = 1; cycle();
    tx_done[2] = 1; cycle();
    // R9 precedence
    wr(3, 4'b1100, 0); cycle();
    grant[3] = 1; wr(3, 4'b1000, 0); cycle();
    tx_done[3] = 1; tx_fail[3] = 1; cycle();
    // R10 set beats clear; error bit
    wr(3, 4'b0010, 0); cycle();
    rx_data[3] = 1; clr_we = 1; clr_pend = 4'b1000; cycle();
    err_det = 1; cycle();
    err_det = 1; clr_we = 1; clr_err = 1; cycle();
    clr_we = 1; clr_err = 1; clr_pend = 4'hF; cycle();

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      r = $urandom();
      if (r[3:0] < 5) begin
        logic [3:0] codes [6];
        codes = '{4'b1000, 4'b1100, 4'b1110, 4'b1010, 4'b0010, 4'b0110};
        wr(int'(r[5:4]), codes[r[8:6] % 6], r[9]);
        if (r[12:10] == 0) wr_code = r[16:13];
      end
      grant = r[19:16] & {4{r[20]}};
      tx_done = r[24:21] & {4{r[25]}};
      tx_fail = ($urandom() & 32'hF) & {4{r[26]}};
      rx_data = ($urandom() & 32'hF) & {4{r[27]}};
      rx_remote = ($urandom() & 32'hF) & {4{r[28]}};
      if (r[31:29] == 0) begin ien_we = 1; ien_data = 4'($urandom()); end
      if (r[31:29] == 1) begin clr_we = 1; clr_pend = 4'($urandom()); clr_err = r[0]; end
      err_det = (r[15:10] == 0);
      cycle();
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule